// File: doc/BRIEF.md
# Vectored Interrupt Entry Sequencer

This block is the control sequencer that takes a 16-bit processor core from normal execution into an interrupt handler and back. It looks at requests only when the execution side signals an instruction boundary. It chooses one pending source under a fixed priority and gets an 8-bit type number for it. The number is fixed for internal sources and comes from an acknowledge handshake for the maskable request line. The block then saves the machine state on the stack and jumps through a vector table held in low memory.

The block owns the code segment, instruction pointer, stack pointer and flag word. On entry it writes three words downward on the stack through a single memory port: the flag word first, then the code segment, then the instruction pointer. It clears the interrupt-enable and single-step flags. It then reads the handler's instruction pointer from address type×4 and its code segment from type×4+2. A return request reverses this. It pops the instruction pointer, the code segment and the flags in that order. Every memory access waits on a ready handshake. Physical stack addresses are the stack segment shifted left by four, plus the stack pointer.

Top module: `isr_entry_seq`

## Requirements
- R1: Reset state is code segment FFFFh, instruction pointer 0000h, stack pointer 0100h and flag word 0000h. The block is not busy, and no memory request or acknowledge is active.
- R2: An entry can only begin in a cycle where `insn_end` is high and the block is idle. With `insn_end` low, pending requests produce no memory traffic. A return begins on `ret_req` when idle and no entry starts in that cycle.
- R3: When several sources are pending at one boundary, the winner is chosen in this order, highest first: internal fault or software request, then the latched NMI, then the enabled maskable request, then single-step.
- R4: Entry performs exactly three word writes. The address is stack_seg×16 + SP. It writes the flag word at SP−2, the code segment at SP−4 and the instruction pointer at SP−6. SP is 6 lower afterwards.
- R5: The pushed flag word is the value held before entry. After the first push, the interrupt-enable bit (bit 9) and the single-step bit (bit 8) are 0, and every other flag bit keeps its value.
- R6: After the pushes, the block reads the word at type×4 into the instruction pointer and the word at type×4+2 into the code segment.
- R7: The maskable request `intr` is ignored while flag bit 9 is 0. When it is accepted, `inta` stays high until `ack_valid`, no memory access occurs meanwhile, and the type used is `ack_type` from that cycle.
- R8: NMI uses type 2. Single-step, taken when flag bit 8 is 1 at a boundary, uses type 1. A fault request uses `fault_type`.
- R9: A rising edge on `nmi` is remembered until it is serviced. A level held high produces only one entry.
- R10: A return reads the instruction pointer at SP, the code segment at SP+2 and the flag word at SP+4. SP ends 6 higher, and no writes occur.
- R11: While `mem_req` is high and `mem_ready` is low, the request, address, direction and write data hold steady into the next cycle. Each access completes only once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| insn_end | input | 1 | Instruction boundary strobe from the execution side |
| fault_req | input | 1 | Internal fault or software interrupt request |
| fault_type | input | 8 | Type number for the fault request |
| nmi | input | 1 | Non-maskable request, edge sensitive |
| intr | input | 1 | Maskable request, level |
| ack_valid | input | 1 | Acknowledge responder presents a type |
| ack_type | input | 8 | Type number returned in the acknowledge |
| ret_req | input | 1 | Return-from-handler request |
| flags_we | input | 1 | Flag word write from the execution side (idle only) |
| flags_wdata | input | 16 | New flag word |
| stack_seg | input | 16 | Stack segment value |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | 20 | Physical byte address (word aligned) |
| mem_wdata | output | 16 | Write data |
| mem_ready | input | 1 | Access completes in this cycle |
| mem_rdata | input | 16 | Read data, valid with `mem_ready` |
| inta | output | 1 | Acknowledge cycle in progress |
| busy | output | 1 | A sequence is running |
| cs_q | output | 16 | Code segment |
| ip_q | output | 16 | Instruction pointer |
| sp_q | output | 16 | Stack pointer |
| flags_q | output | 16 | Flag word |

## Verification
Entry is driven by a fault request alone, by all four sources raised at once, by NMI with the maskable line and single-step also pending, and by the maskable line with single-step set. The sequence of winners and the vectors they load separate a correct priority chain from a reordered or mis-typed one. The maskable line is tried with the enable bit clear and with acknowledge delays of two and five cycles. These cases tell a masked request from an accepted one and show whether the type is taken at the right moment. NMI is tried both as a short pulse served later and as a held level across two boundaries, which tells edge latching from level sampling. Entry and return are also run against a memory that stalls on alternate cycles, which exposes repeated or skipped stack and vector accesses.

// File: rtl/isr_pkg.sv
package isr_pkg;

   typedef enum logic [3:0] {
      ST_IDLE,
      ST_ACK,
      ST_PUSH_F,
      ST_PUSH_CS,
      ST_PUSH_IP,
      ST_RD_IP,
      ST_RD_CS,
      ST_POP_IP,
      ST_POP_CS,
      ST_POP_F
   } seq_state_t;

   // request slots, index order is priority order (0 highest)
   localparam int SRC_FAULT = 0;
   localparam int SRC_NMI   = 1;
   localparam int SRC_INTR  = 2;
   localparam int SRC_STEP  = 3;
   localparam int SRC_COUNT = 4;

endpackage

// File: rtl/isr_nmi_latch.sv
module isr_nmi_latch #(
   parameter int EDGE_MODE = 1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic nmi_in,
   input  logic clr,
   output logic pend
);

   generate
      if (EDGE_MODE != 0) begin : g_edge
         logic nmi_q;
         logic pend_q;
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               nmi_q  <= 1'b0;
               pend_q <= 1'b0;
            end else begin
               nmi_q  <= nmi_in;
               pend_q <= (pend_q & ~clr) | (nmi_in & ~nmi_q);
            end
         end
         assign pend = pend_q;
      end else begin : g_level
         logic unused_clr;
         assign unused_clr = clr;
         assign pend = nmi_in;
      end
   endgenerate

endmodule

// File: rtl/isr_arbiter.sv
module isr_arbiter #(
   parameter int N = 4
) (
   input  logic [N-1:0] req,
   output logic [N-1:0] gnt
);

   generate
      if (N < 1) begin : g_bad_n
         $error("isr_arbiter needs at least one requester");
      end
      for (genvar i = 0; i < N; i++) begin : g_slot
         if (i == 0) begin : g_top
            assign gnt[i] = req[i];
         end else begin : g_rest
            assign gnt[i] = req[i] & ~(|req[i-1:0]);
         end
      end
   endgenerate

endmodule

// File: rtl/isr_addr_gen.sv
module isr_addr_gen #(
   parameter int DATA_W    = 16,
   parameter int ADDR_W    = 20,
   parameter int SEG_SHIFT = 4
) (
   input  logic [DATA_W-1:0] seg,
   input  logic [DATA_W-1:0] off,
   output logic [ADDR_W-1:0] addr
);

   localparam int SUM_W = DATA_W + SEG_SHIFT + 1;

   logic [SUM_W-1:0] sum;

   generate
      if (ADDR_W > SUM_W) begin : g_bad_w
         $error("isr_addr_gen: address wider than segment sum");
      end
      if (SEG_SHIFT == 0) begin : g_flat
         assign sum = SUM_W'(seg) + SUM_W'(off);
      end else begin : g_shift
         assign sum = {1'b0, seg, {SEG_SHIFT{1'b0}}} + SUM_W'(off);
      end
   endgenerate

   assign addr = sum[ADDR_W-1:0];

endmodule

// File: rtl/isr_entry_seq.sv
module isr_entry_seq
   import isr_pkg::*;
#(
   parameter int DATA_W    = 16,
   parameter int ADDR_W    = 20,
   parameter int TYPE_W    = 8,
   parameter int SEG_SHIFT = 4,
   parameter int IF_BIT    = 9,
   parameter int TF_BIT    = 8,
   parameter int NMI_EDGE  = 1,
   parameter logic [DATA_W-1:0] CS_RST    = 'hFFFF,
   parameter logic [DATA_W-1:0] IP_RST    = 'h0000,
   parameter logic [DATA_W-1:0] SP_RST    = 'h0100,
   parameter logic [TYPE_W-1:0] NMI_TYPE  = 'd2,
   parameter logic [TYPE_W-1:0] STEP_TYPE = 'd1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              insn_end,
   input  logic              fault_req,
   input  logic [TYPE_W-1:0] fault_type,
   input  logic              nmi,
   input  logic              intr,
   input  logic              ack_valid,
   input  logic [TYPE_W-1:0] ack_type,
   input  logic              ret_req,
   input  logic              flags_we,
   input  logic [DATA_W-1:0] flags_wdata,
   input  logic [DATA_W-1:0] stack_seg,
   output logic              mem_req,
   output logic              mem_we,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [DATA_W-1:0] mem_wdata,
   input  logic              mem_ready,
   input  logic [DATA_W-1:0] mem_rdata,
   output logic              inta,
   output logic              busy,
   output logic [DATA_W-1:0] cs_q,
   output logic [DATA_W-1:0] ip_q,
   output logic [DATA_W-1:0] sp_q,
   output logic [DATA_W-1:0] flags_q
);

   localparam int WORD_BYTES = DATA_W / 8;
   localparam int VEC_SHIFT  = $clog2(2 * WORD_BYTES);
   localparam logic [DATA_W-1:0] WSTEP   = DATA_W'(WORD_BYTES);
   localparam logic [ADDR_W-1:0] WSTEP_A = ADDR_W'(WORD_BYTES);

   generate
      if (DATA_W % 8 != 0 || DATA_W < 16) begin : g_bad_data
         $error("isr_entry_seq: word width must be a multiple of 8, at least 16");
      end
      if (ADDR_W <= TYPE_W + VEC_SHIFT) begin : g_bad_vec
         $error("isr_entry_seq: address too narrow for the vector table");
      end
      if (IF_BIT >= DATA_W || TF_BIT >= DATA_W || IF_BIT == TF_BIT) begin : g_bad_flag
         $error("isr_entry_seq: flag bit positions out of range");
      end
   endgenerate

   seq_state_t        st_q;
   logic [DATA_W-1:0] cs_r, ip_r, sp_r, flg_r, ip_hold;
   logic [TYPE_W-1:0] type_r;
   logic              nmi_pend, nmi_clr;
   logic [SRC_COUNT-1:0] src_req, src_gnt;
   logic              take, xfer, pushing;
   logic [DATA_W-1:0] stk_off;
   logic [ADDR_W-1:0] stk_addr, vec_addr;

   // ---------------- request side ----------------
   isr_nmi_latch #(.EDGE_MODE(NMI_EDGE)) u_nmi (
      .clk    (clk),
      .rst_n  (rst_n),
      .nmi_in (nmi),
      .clr    (nmi_clr),
      .pend   (nmi_pend)
   );

   assign src_req[SRC_FAULT] = fault_req;
   assign src_req[SRC_NMI]   = nmi_pend;
   assign src_req[SRC_INTR]  = intr & flg_r[IF_BIT];
   assign src_req[SRC_STEP]  = flg_r[TF_BIT];

   isr_arbiter #(.N(SRC_COUNT)) u_arb (
      .req (src_req),
      .gnt (src_gnt)
   );

   assign take    = (st_q == ST_IDLE) && insn_end && (|src_req);
   assign nmi_clr = take && src_gnt[SRC_NMI];

   // ---------------- address side ----------------
   assign pushing = (st_q == ST_PUSH_F) || (st_q == ST_PUSH_CS) || (st_q == ST_PUSH_IP);
   assign stk_off = pushing ? (sp_r - WSTEP) : sp_r;

   isr_addr_gen #(
      .DATA_W    (DATA_W),
      .ADDR_W    (ADDR_W),
      .SEG_SHIFT (SEG_SHIFT)
   ) u_stk (
      .seg  (stack_seg),
      .off  (stk_off),
      .addr (stk_addr)
   );

   assign vec_addr = ADDR_W'(type_r) << VEC_SHIFT;

   always_comb begin
      mem_req   = 1'b0;
      mem_we    = 1'b0;
      mem_wdata = '0;
      mem_addr  = stk_addr;
      case (st_q)
         ST_PUSH_F:  begin mem_req = 1'b1; mem_we = 1'b1; mem_wdata = flg_r; end
         ST_PUSH_CS: begin mem_req = 1'b1; mem_we = 1'b1; mem_wdata = cs_r;  end
         ST_PUSH_IP: begin mem_req = 1'b1; mem_we = 1'b1; mem_wdata = ip_r;  end
         ST_RD_IP:   begin mem_req = 1'b1; mem_addr = vec_addr;            end
         ST_RD_CS:   begin mem_req = 1'b1; mem_addr = vec_addr + WSTEP_A;  end
         ST_POP_IP, ST_POP_CS, ST_POP_F: mem_req = 1'b1;
         default: ;
      endcase
   end

   assign xfer = mem_req && mem_ready;

   // ---------------- sequencer ----------------
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q    <= ST_IDLE;
         cs_r    <= CS_RST;
         ip_r    <= IP_RST;
         sp_r    <= SP_RST;
         flg_r   <= '0;
         ip_hold <= '0;
         type_r  <= '0;
      end else begin
         case (st_q)
            ST_IDLE: begin
               if (flags_we) flg_r <= flags_wdata;
               if (take) begin
                  if (src_gnt[SRC_INTR]) begin
                     st_q <= ST_ACK;
                  end else begin
                     st_q   <= ST_PUSH_F;
                     type_r <= src_gnt[SRC_FAULT] ? fault_type :
                               src_gnt[SRC_NMI]   ? NMI_TYPE   : STEP_TYPE;
                  end
               end else if (ret_req) begin
                  st_q <= ST_POP_IP;
               end
            end
            ST_ACK: begin
               if (ack_valid) begin
                  type_r <= ack_type;
                  st_q   <= ST_PUSH_F;
               end
            end
            ST_PUSH_F: begin
               if (xfer) begin
                  sp_r          <= sp_r - WSTEP;
                  flg_r[IF_BIT] <= 1'b0;
                  flg_r[TF_BIT] <= 1'b0;
                  st_q          <= ST_PUSH_CS;
               end
            end
            ST_PUSH_CS: begin
               if (xfer) begin
                  sp_r <= sp_r - WSTEP;
                  st_q <= ST_PUSH_IP;
               end
            end
            ST_PUSH_IP: begin
               if (xfer) begin
                  sp_r <= sp_r - WSTEP;
                  st_q <= ST_RD_IP;
               end
            end
            ST_RD_IP: begin
               if (xfer) begin
                  ip_hold <= mem_rdata;
                  st_q    <= ST_RD_CS;
               end
            end
            ST_RD_CS: begin
               if (xfer) begin
                  cs_r <= mem_rdata;
                  ip_r <= ip_hold;
                  st_q <= ST_IDLE;
               end
            end
            ST_POP_IP: begin
               if (xfer) begin
                  ip_r <= mem_rdata;
                  sp_r <= sp_r + WSTEP;
                  st_q <= ST_POP_CS;
               end
            end
            ST_POP_CS: begin
               if (xfer) begin
                  cs_r <= mem_rdata;
                  sp_r <= sp_r + WSTEP;
                  st_q <= ST_POP_F;
               end
            end
            ST_POP_F: begin
               if (xfer) begin
                  flg_r <= mem_rdata;
                  sp_r  <= sp_r + WSTEP;
                  st_q  <= ST_IDLE;
               end
            end
            default: st_q <= ST_IDLE;
         endcase
      end
   end

   assign inta    = (st_q == ST_ACK);
   assign busy    = (st_q != ST_IDLE);
   assign cs_q    = cs_r;
   assign ip_q    = ip_r;
   assign sp_q    = sp_r;
   assign flags_q = flg_r;

endmodule

// File: rtl/isr_entry_seq_chk.sv
module isr_entry_seq_chk #(
   parameter int DATA_W = 16,
   parameter int ADDR_W = 20,
   parameter int IF_BIT = 9,
   parameter int TF_BIT = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              insn_end,
   input logic              ret_req,
   input logic              busy,
   input logic              inta,
   input logic              mem_req,
   input logic              mem_we,
   input logic              mem_ready,
   input logic [ADDR_W-1:0] mem_addr,
   input logic [DATA_W-1:0] mem_wdata,
   input logic [DATA_W-1:0] flags_q
);

   // R2: a sequence only starts after a boundary strobe or a return request
   p_start_cause_r2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> ($past(insn_end) || $past(ret_req)));

   // R11: a stalled access holds its request steady
   p_stall_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && !mem_ready) |=> (mem_req && $stable(mem_addr) &&
                                   $stable(mem_we) && $stable(mem_wdata)));

   // R5: once a stack write completes, both masking flags read as clear
   p_mask_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && mem_we && mem_ready) |=> (!flags_q[IF_BIT] && !flags_q[TF_BIT]));

   // R7: no memory traffic during the acknowledge handshake
   p_ack_no_mem_r7: assert property (@(posedge clk) disable iff (!rst_n)
      inta |-> !mem_req);

   // R4: every access is word aligned
   p_word_align_r4: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req |-> !mem_addr[0]);

endmodule

bind isr_entry_seq isr_entry_seq_chk #(
   .DATA_W (DATA_W),
   .ADDR_W (ADDR_W),
   .IF_BIT (IF_BIT),
   .TF_BIT (TF_BIT)
) u_chk (.*);

// File: tb/isr_entry_seq_tb.sv
`timescale 1ns/100ps
module isr_entry_seq_tb;

   localparam logic [15:0] STK_SEG  = 16'h2000;
   localparam logic [19:0] STK_BASE = 20'h20000;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        insn_end = 1'b0, fault_req = 1'b0, nmi = 1'b0, intr = 1'b0;
   logic [7:0]  fault_type = 8'h00, ack_type = 8'h00;
   logic        ack_valid = 1'b0, ret_req = 1'b0, flags_we = 1'b0;
   logic [15:0] flags_wdata = 16'h0000;
   logic        mem_req, mem_we, mem_ready, inta, busy;
   logic [19:0] mem_addr;
   logic [15:0] mem_wdata, mem_rdata, cs_q, ip_q, sp_q, flags_q;

   logic        stall_en = 1'b0, stall_tog = 1'b0;
   int          ack_delay = 1, ack_cnt = 0;
   int          n_chk = 0, n_bad = 0;
   int          wr_cnt = 0, inta_cnt = 0;
   logic [19:0] wl_addr [0:63];
   logic [15:0] wl_data [0:63];
   logic [15:0] vmem [0:511];
   logic [15:0] smem [0:127];

   always #2.5 clk = ~clk;

   isr_entry_seq u_dut (
      .clk(clk), .rst_n(rst_n), .insn_end(insn_end), .fault_req(fault_req),
      .fault_type(fault_type), .nmi(nmi), .intr(intr), .ack_valid(ack_valid),
      .ack_type(ack_type), .ret_req(ret_req), .flags_we(flags_we),
      .flags_wdata(flags_wdata), .stack_seg(STK_SEG), .mem_req(mem_req),
      .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
      .mem_ready(mem_ready), .mem_rdata(mem_rdata), .inta(inta), .busy(busy),
      .cs_q(cs_q), .ip_q(ip_q), .sp_q(sp_q), .flags_q(flags_q)
   );

   // ---------------- memory model ----------------
   always @(posedge clk) stall_tog <= ~stall_tog;
   assign mem_ready = !stall_en || stall_tog;

   always_comb begin
      if (mem_addr < 20'h00400) mem_rdata = vmem[mem_addr[9:1]];
      else                      mem_rdata = smem[mem_addr[7:1]];
   end

   always @(negedge clk) begin
      #1;
      if (mem_req && mem_we && mem_ready) begin
         wl_addr[wr_cnt % 64] = mem_addr;
         wl_data[wr_cnt % 64] = mem_wdata;
         if (mem_addr >= STK_BASE) smem[mem_addr[7:1]] = mem_wdata;
         wr_cnt++;
      end
      if (inta) inta_cnt++;
   end

   // acknowledge responder
   always @(negedge clk) begin
      if (inta) begin
         ack_cnt++;
         ack_valid = (ack_cnt >= ack_delay);
      end else begin
         ack_cnt   = 0;
         ack_valid = 1'b0;
      end
   end

   function automatic logic [15:0] vip(input logic [7:0] t);
      return 16'h1000 | {8'h00, t};
   endfunction
   function automatic logic [15:0] vcs(input logic [7:0] t);
      return 16'h4000 | {4'h0, t, 4'h0};
   endfunction

   // ---------------- helpers ----------------
   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
      end
   endtask

   task automatic cyc(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   task automatic wait_idle();
      for (int i = 0; i < 200 && busy; i++) @(negedge clk);
   endtask

   task automatic set_flags(input logic [15:0] v);
      @(negedge clk); flags_we = 1'b1; flags_wdata = v;
      @(negedge clk); flags_we = 1'b0;
   endtask

   task automatic boundary();
      @(negedge clk); insn_end = 1'b1;
      @(negedge clk); insn_end = 1'b0;
   endtask

   // run one entry from the current state and compare the stack image
   task automatic entry_and_check(input string req, input logic [7:0] t);
      logic [15:0] pf, pcs, pip, psp;
      int base;
      pf = flags_q; pcs = cs_q; pip = ip_q; psp = sp_q; base = wr_cnt;
      boundary();
      wait_idle();
      chk({req, " busy end"}, busy, 0);
      chk("R4 write count", wr_cnt - base, 3);
      chk("R4 flags push addr", wl_addr[base % 64], STK_BASE + psp - 2);
      chk("R5 pushed flags", wl_data[base % 64], pf);
      chk("R4 cs push addr", wl_addr[(base + 1) % 64], STK_BASE + psp - 4);
      chk("R4 cs push data", wl_data[(base + 1) % 64], pcs);
      chk("R4 ip push addr", wl_addr[(base + 2) % 64], STK_BASE + psp - 6);
      chk("R4 ip push data", wl_data[(base + 2) % 64], pip);
      chk("R4 sp after", sp_q, psp - 16'd6);
      chk("R5 flags after", flags_q, pf & ~16'h0300);
      chk({req, " R6 ip from vector"}, ip_q, vip(t));
      chk({req, " R6 cs from vector"}, cs_q, vcs(t));
   endtask

   // ---------------- scenarios ----------------
   task automatic t_reset();
      rst_n = 1'b0;
      cyc(4);
      rst_n = 1'b1;
      cyc(1);
      chk("R1 cs", cs_q, 16'hFFFF);
      chk("R1 ip", ip_q, 16'h0000);
      chk("R1 sp", sp_q, 16'h0100);
      chk("R1 flags", flags_q, 16'h0000);
      chk("R1 busy", busy, 0);
      chk("R1 mem_req", mem_req, 0);
      chk("R1 inta", inta, 0);
   endtask

   task automatic t_boundary();
      int base;
      base = wr_cnt;
      @(negedge clk); fault_req = 1'b1; fault_type = 8'h21;
      cyc(4);
      chk("R2 no start without boundary", busy, 0);
      chk("R2 no writes without boundary", wr_cnt - base, 0);
      entry_and_check("R8 fault type", 8'h21);
      @(negedge clk); fault_req = 1'b0;
   endtask

   task automatic t_mask();
      int base;
      logic [15:0] pip;
      base = wr_cnt; pip = ip_q;
      set_flags(16'h0000);
      @(negedge clk); intr = 1'b1;
      boundary();
      cyc(2);
      chk("R7 masked busy", busy, 0);
      chk("R7 masked inta", inta, 0);
      chk("R7 masked writes", wr_cnt - base, 0);
      chk("R7 masked ip", ip_q, pip);
      @(negedge clk); intr = 1'b0;
   endtask

   task automatic t_priority();
      int ib;
      set_flags(16'h0341);
      @(negedge clk); fault_req = 1'b1; fault_type = 8'h05; intr = 1'b1; nmi = 1'b1;
      @(negedge clk); nmi = 1'b0;
      cyc(2);
      entry_and_check("R3 fault first", 8'h05);
      @(negedge clk); fault_req = 1'b0;
      set_flags(16'h0341);
      entry_and_check("R3 R9 latched nmi second", 8'h02);
      set_flags(16'h0341);
      ack_type = 8'h40; ack_delay = 2; ib = inta_cnt;
      entry_and_check("R3 intr third", 8'h40);
      chk("R7 inta cycles", inta_cnt - ib, 2);
      @(negedge clk); intr = 1'b0;
      set_flags(16'h0141);
      entry_and_check("R3 R8 single-step last", 8'h01);
   endtask

   task automatic t_ack_delay();
      int ib;
      set_flags(16'h0200);
      @(negedge clk); intr = 1'b1; ack_type = 8'h7E; ack_delay = 5; ib = inta_cnt;
      entry_and_check("R7 ack type", 8'h7E);
      chk("R7 inta held until ack", inta_cnt - ib, 5);
      @(negedge clk); intr = 1'b0;
   endtask

   task automatic t_nmi_hold();
      int base;
      @(negedge clk); nmi = 1'b1;
      cyc(3);
      entry_and_check("R8 nmi type", 8'h02);
      base = wr_cnt;
      boundary();
      cyc(2);
      chk("R9 held level no second entry", busy, 0);
      chk("R9 held level no writes", wr_cnt - base, 0);
      @(negedge clk); nmi = 1'b0;
   endtask

   task automatic t_return(input string tag);
      logic [15:0] pf, pcs, pip, psp;
      int base;
      set_flags(16'h0203);
      pf = flags_q; pcs = cs_q; pip = ip_q; psp = sp_q;
      @(negedge clk); fault_req = 1'b1; fault_type = 8'h33;
      entry_and_check({tag, " entry"}, 8'h33);
      @(negedge clk); fault_req = 1'b0;
      base = wr_cnt;
      @(negedge clk); ret_req = 1'b1;
      @(negedge clk); ret_req = 1'b0;
      wait_idle();
      chk({tag, " R10 ip restored"}, ip_q, pip);
      chk({tag, " R10 cs restored"}, cs_q, pcs);
      chk({tag, " R10 flags restored"}, flags_q, pf);
      chk({tag, " R10 sp restored"}, sp_q, psp);
      chk({tag, " R10 no writes"}, wr_cnt - base, 0);
   endtask

   task automatic t_stall();
      @(negedge clk); stall_en = 1'b1;
      @(negedge clk); fault_req = 1'b1; fault_type = 8'h44;
      entry_and_check("R11 stalled entry", 8'h44);
      @(negedge clk); fault_req = 1'b0;
      t_return("R11 stalled");
      @(negedge clk); stall_en = 1'b0;
   endtask

   initial begin
      for (int t = 0; t < 256; t++) begin
         vmem[2 * t]     = vip(8'(t));
         vmem[2 * t + 1] = vcs(8'(t));
      end
      for (int i = 0; i < 128; i++) smem[i] = 16'h0000;
      t_reset();
      t_boundary();
      t_mask();
      t_priority();
      t_ack_delay();
      t_nmi_hold();
      t_return("plain");
      t_stall();
      cyc(2);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

endmodule